// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block lets a clocked system perform single-word reads and writes on an external asynchronous static RAM with a 17-bit word address, a 16-bit data bus split into two byte lanes, and active-low chip, output, write and per-lane enables. The user side offers one request at a time. A request is accepted when `req_valid` and `req_ready` are both high. It carries an address, a write flag, one enable bit per byte lane and write data. Completion is signalled by a single-cycle `rsp_valid` pulse, with read data on `rsp_rdata`.

Every strobe phase is timed by counting clock cycles. Each count is the ceiling of a nanosecond limit divided by `CLK_NS`, and never less than one. The limits are parameters, so one netlist covers any speed grade and clock. Each access runs through five phases:

- idle
- a setup cycle, with the address driven and all strobes high
- the strobe pulse
- a closing cycle, with all strobes high
- a recovery window, whose length lets the RAM release the bus before the next access

The data bus is split into a drive value, a drive enable and an input, so the pad ring makes the tristate.

Top module: `asram_ctrl`

## Requirements
- R1: During a write, chip enable and write enable are low together, and only the lanes whose request enable bit is set are pulled low. Bit 0 maps to `ram_be_n[0]` and data bits 7..0. Bit 1 maps to `ram_be_n[1]` and bits 15..8. Output enable stays high for the whole write.
- R2: The write strobe stays low for WR = max(ceil(45/T), ceil(50/T), ceil(25/T)) cycles, which is 10 at T = 5 ns. The write data is driven from the setup cycle through the closing cycle.
- R3: During a read, chip enable and output enable are low and write enable is high. The enabled lanes are low for RD = ceil(55/T) + 1 cycles, which is 12 at T = 5 ns. The extra cycle covers the input register.
- R4: A read returns the RAM word on lanes whose enable bit is set, and zero on lanes whose bit is clear. A write response carries zero.
- R5: `rsp_valid` is high for exactly one cycle per request. It is high in the cycle after the edge that ends the strobe pulse, which is 2 + pulse cycles after the accepting edge.
- R6: The address changes only when chip enable, write enable and both lane enables are high in that cycle and in the cycle before. The address holds from acceptance until the next acceptance.
- R7: The controller drives the bus only from the setup cycle to the closing cycle of a write, and never while output enable is low. At least HZ = ceil(20/T) cycles separate the end of controller drive from any output-enable fall. At least HZ cycles also separate output-enable rising from any new drive.
- R8: After the closing cycle, a recovery of REC = max(HZ, ceil(55/T) − 2 − min(WR, RD)) cycles keeps all strobes high, which is 4 at T = 5 ns. `req_ready` is high only when the block is idle, and in that state all strobes are high and the bus is not driven.
- R9: While reset is low, all strobes are high, the bus drive is off, `rsp_valid` is low and `req_ready` is high.
- R10: A write with a lane's enable bit clear leaves that lane's stored byte unchanged, as seen by a later full-word read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken this edge if valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_be | input | 2 | Lane enables, bit 0 low byte, bit 1 high byte |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| ram_addr | output | 17 | RAM address |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_be_n | output | 2 | RAM lane enables, active low, bit 0 low byte |
| ram_dq_out | output | 16 | Data driven toward the RAM |
| ram_dq_oe | output | 1 | Drive enable for `ram_dq_out` |
| ram_dq_in | input | 16 | Data returned from the RAM pins |

## Verification
The assertions take for granted that the RAM model releases its pins whenever output enable or chip enable is high. They also assume that the requester presents at most one request per idle period and never asks for anything while `req_ready` is low. The stimulus meets this by raising `req_valid` only after its own model reports the block idle, and by dropping it right after the accepting edge. Read data in the bench's RAM model becomes valid one nanosecond before the 55 ns access limit and is garbage before that, so any shortening of the read pulse shows up as wrong data. Lanes the RAM is not driving also carry garbage, so zeroing of disabled lanes is observable.

// File: rtl/asram_pkg.sv
// Shared types and cycle-count helpers for the asynchronous SRAM controller.
// Assumes all timing limits are given in whole nanoseconds.
package asram_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ACCESS,
        PH_CLOSE,
        PH_RECOVER
    } phase_t;

    // Clock cycles needed to cover ns nanoseconds, never below one.
    function automatic int cyc_of(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max_i(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int min_i(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_seq.sv
// Phase sequencer: walks idle -> setup -> access -> close -> recover -> idle,
// holding each timed phase for its parameter count.
// Assumes op_we is stable from the setup phase onward.
module asram_seq
    import asram_pkg::*;
#(
    parameter int SETUP_CYC = 1,
    parameter int WR_CYC    = 10,
    parameter int RD_CYC    = 12,
    parameter int REC_CYC   = 4
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   op_we,
    output phase_t state,
    output phase_t nxt
);

    localparam int MAXC = max_i(max_i(SETUP_CYC, REC_CYC), max_i(WR_CYC, RD_CYC));
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] load;
    logic          expired;

    assign expired = (cnt == '0);

    // Next phase from the current phase and the remaining count.
    always_comb begin
        nxt = state;
        unique case (state)
            PH_IDLE:    if (start)   nxt = PH_SETUP;
            PH_SETUP:   if (expired) nxt = PH_ACCESS;
            PH_ACCESS:  if (expired) nxt = PH_CLOSE;
            PH_CLOSE:                nxt = PH_RECOVER;
            PH_RECOVER: if (expired) nxt = PH_IDLE;
            default:                 nxt = PH_IDLE;
        endcase
    end

    // Length of the phase being entered, minus one.
    always_comb begin
        unique case (nxt)
            PH_SETUP:   load = CW'(SETUP_CYC - 1);
            PH_ACCESS:  load = op_we ? CW'(WR_CYC - 1) : CW'(RD_CYC - 1);
            PH_RECOVER: load = CW'(REC_CYC - 1);
            default:    load = '0;
        endcase
    end

    // Phase register and down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PH_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (nxt != state) cnt <= load;
            else if (!expired) cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/asram_io.sv
// Pin stage: latches the request, drives registered strobes from the next
// phase, registers the returned data and assembles the per-lane response.
// Assumes accept is only high while the sequencer is idle.
module asram_io
    import asram_pkg::*;
#(
    parameter int AW    = 17,
    parameter int LANES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accept,
    input  logic               req_we,
    input  logic [AW-1:0]      req_addr,
    input  logic [LANES-1:0]   req_be,
    input  logic [8*LANES-1:0] req_wdata,
    input  phase_t             state,
    input  phase_t             nxt,
    output logic               op_we,
    output logic [AW-1:0]      ram_addr,
    output logic               ram_ce_n,
    output logic               ram_oe_n,
    output logic               ram_we_n,
    output logic [LANES-1:0]   ram_be_n,
    output logic [8*LANES-1:0] ram_dq_out,
    output logic               ram_dq_oe,
    input  logic [8*LANES-1:0] ram_dq_in,
    output logic               rsp_valid,
    output logic [8*LANES-1:0] rsp_rdata
);

    localparam int DW = 8 * LANES;

    logic [AW-1:0]    addr_q;
    logic             we_q;
    logic [LANES-1:0] be_q;
    logic [DW-1:0]    wdat_q;
    logic [DW-1:0]    din_q;
    logic             pulse_on;
    logic             op_next;
    logic             finish;

    assign pulse_on   = (nxt == PH_ACCESS);
    assign op_next    = accept ? req_we : we_q;
    assign finish     = (state == PH_ACCESS) && (nxt == PH_CLOSE);
    assign op_we      = we_q;
    assign ram_addr   = addr_q;
    assign ram_dq_out = wdat_q;

    // Capture the request fields on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            we_q   <= 1'b0;
            be_q   <= '0;
            wdat_q <= '0;
        end else if (accept) begin
            addr_q <= req_addr;
            we_q   <= req_we;
            be_q   <= req_be;
            wdat_q <= req_wdata;
        end
    end

    // Register the RAM data pins every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) din_q <= '0;
        else        din_q <= ram_dq_in;
    end

    // Shared strobes, bus drive and completion pulse, registered from the next phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_ce_n  <= 1'b1;
            ram_we_n  <= 1'b1;
            ram_oe_n  <= 1'b1;
            ram_dq_oe <= 1'b0;
            rsp_valid <= 1'b0;
        end else begin
            ram_ce_n  <= !pulse_on;
            ram_we_n  <= !(pulse_on && we_q);
            ram_oe_n  <= !(pulse_on && !we_q);
            ram_dq_oe <= op_next && (nxt inside {PH_SETUP, PH_ACCESS, PH_CLOSE});
            rsp_valid <= finish;
        end
    end

    // One enable and one response byte per lane.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // Lane strobe and read-data slice for lane i.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ram_be_n[i]        <= 1'b1;
                rsp_rdata[8*i +: 8] <= '0;
            end else begin
                ram_be_n[i] <= !(pulse_on && be_q[i]);
                if (finish)
                    rsp_rdata[8*i +: 8] <= (!we_q && be_q[i]) ? din_q[8*i +: 8] : 8'h00;
            end
        end
    end

endmodule

// File: rtl/asram_ctrl.sv
// Top of the asynchronous SRAM controller: derives cycle counts from the
// nanosecond limits and the clock period, then joins sequencer and pin stage.
// Assumes one outstanding request; the requester waits for req_ready.
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int AW       = 17,
    parameter int LANES    = 2,
    parameter int CLK_NS   = 5,
    parameter int T_RC_NS  = 55,
    parameter int T_WP_NS  = 45,
    parameter int T_AW_NS  = 50,
    parameter int T_DW_NS  = 25,
    parameter int T_AA_NS  = 55,
    parameter int T_ACE_NS = 55,
    parameter int T_OE_NS  = 30,
    parameter int T_HZ_NS  = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_we,
    input  logic [AW-1:0]      req_addr,
    input  logic [LANES-1:0]   req_be,
    input  logic [8*LANES-1:0] req_wdata,
    output logic               rsp_valid,
    output logic [8*LANES-1:0] rsp_rdata,
    output logic [AW-1:0]      ram_addr,
    output logic               ram_ce_n,
    output logic               ram_oe_n,
    output logic               ram_we_n,
    output logic [LANES-1:0]   ram_be_n,
    output logic [8*LANES-1:0] ram_dq_out,
    output logic               ram_dq_oe,
    input  logic [8*LANES-1:0] ram_dq_in
);

    localparam int SETUP_CYC = 1;
    localparam int WR_CYC = max_i(max_i(cyc_of(T_WP_NS, CLK_NS), cyc_of(T_AW_NS, CLK_NS)),
                                  cyc_of(T_DW_NS, CLK_NS));
    localparam int RD_CYC = max_i(max_i(cyc_of(T_AA_NS, CLK_NS), cyc_of(T_ACE_NS, CLK_NS)),
                                  cyc_of(T_OE_NS, CLK_NS)) + 1;
    localparam int HZ_CYC  = cyc_of(T_HZ_NS, CLK_NS);
    localparam int REC_CYC = max_i(HZ_CYC,
                                   cyc_of(T_RC_NS, CLK_NS) - 2 - min_i(WR_CYC, RD_CYC));

    phase_t state;
    phase_t nxt;
    logic   op_we;
    logic   accept;

    assign req_ready = (state == PH_IDLE);
    assign accept    = req_valid && req_ready;

    asram_seq #(
        .SETUP_CYC (SETUP_CYC),
        .WR_CYC    (WR_CYC),
        .RD_CYC    (RD_CYC),
        .REC_CYC   (REC_CYC)
    ) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .op_we (op_we),
        .state (state),
        .nxt   (nxt)
    );

    asram_io #(
        .AW    (AW),
        .LANES (LANES)
    ) u_io (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .req_we     (req_we),
        .req_addr   (req_addr),
        .req_be     (req_be),
        .req_wdata  (req_wdata),
        .state      (state),
        .nxt        (nxt),
        .op_we      (op_we),
        .ram_addr   (ram_addr),
        .ram_ce_n   (ram_ce_n),
        .ram_oe_n   (ram_oe_n),
        .ram_we_n   (ram_we_n),
        .ram_be_n   (ram_be_n),
        .ram_dq_out (ram_dq_out),
        .ram_dq_oe  (ram_dq_oe),
        .ram_dq_in  (ram_dq_in),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata)
    );

endmodule

// File: rtl/asram_ctrl_chk.sv
// Protocol checker for the SRAM pins and the response handshake, bound to
// asram_ctrl. Pulse widths and bus gaps are measured with counters.
// Assumes the pin-side counts match those derived in the top module.
module asram_ctrl_chk #(
    parameter int AW     = 17,
    parameter int LANES  = 2,
    parameter int TA_CYC = 4,
    parameter int WR_CYC = 10,
    parameter int RD_CYC = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic [AW-1:0]    ram_addr,
    input logic             ram_ce_n,
    input logic             ram_oe_n,
    input logic             ram_we_n,
    input logic [LANES-1:0] ram_be_n,
    input logic             ram_dq_oe
);

    int wrun;
    int rrun;
    int since_drv;
    int since_rd;

    // Length of the current low pulse on each strobe, and time since each bus driver was last on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wrun      <= 0;
            rrun      <= 0;
            since_drv <= TA_CYC;
            since_rd  <= TA_CYC;
        end else begin
            wrun <= ram_we_n ? 0 : wrun + 1;
            rrun <= ram_oe_n ? 0 : rrun + 1;
            if (ram_dq_oe)            since_drv <= 0;
            else if (since_drv < TA_CYC) since_drv <= since_drv + 1;
            if (!ram_oe_n)            since_rd <= 0;
            else if (since_rd < TA_CYC) since_rd <= since_rd + 1;
        end
    end

    AST_WR_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> ram_oe_n); // R1
    AST_WR_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_we_n) |-> (wrun >= WR_CYC)); // R2
    AST_RD_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_oe_n) |-> (rrun >= RD_CYC)); // R3
    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R5
    AST_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ram_addr) |-> (ram_ce_n && ram_we_n && (&ram_be_n)
                                && $past(ram_ce_n) && $past(ram_we_n) && (&$past(ram_be_n)))); // R6
    AST_NO_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        ram_dq_oe |-> ram_oe_n); // R7
    AST_GAP_BEFORE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ram_oe_n) |-> (since_drv >= TA_CYC)); // R7
    AST_GAP_BEFORE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_dq_oe) |-> (since_rd >= TA_CYC)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ram_ce_n && ram_we_n && ram_oe_n && (&ram_be_n) && !ram_dq_oe)); // R8

endmodule

bind asram_ctrl asram_ctrl_chk #(
    .AW     (AW),
    .LANES  (LANES),
    .TA_CYC (HZ_CYC),
    .WR_CYC (WR_CYC),
    .RD_CYC (RD_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .ram_addr  (ram_addr),
    .ram_ce_n  (ram_ce_n),
    .ram_oe_n  (ram_oe_n),
    .ram_we_n  (ram_we_n),
    .ram_be_n  (ram_be_n),
    .ram_dq_oe (ram_dq_oe)
);

// File: tb/tb_asram_ctrl.sv
`timescale 1ns/1ps
// Bench: behavioural SRAM pin model plus a cycle-indexed reference of the
// expected pin and handshake values, compared on every falling edge.
module tb_asram_ctrl;

    localparam int CLK_NS = 5;
    localparam int AW     = 17;
    localparam int LANES  = 2;
    localparam int DW     = 16;

    function automatic int cdiv(input int ns);
        int c;
        c = (ns + CLK_NS - 1) / CLK_NS;
        return (c < 1) ? 1 : c;
    endfunction

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_we = 1'b0;
    logic [AW-1:0]   req_addr = '0;
    logic [1:0]      req_be = '0;
    logic [DW-1:0]   req_wdata = '0;
    logic            req_ready;
    logic            rsp_valid;
    logic [DW-1:0]   rsp_rdata;
    logic [AW-1:0]   ram_addr;
    logic            ram_ce_n, ram_oe_n, ram_we_n;
    logic [1:0]      ram_be_n;
    logic [DW-1:0]   ram_dq_out;
    logic            ram_dq_oe;
    logic [DW-1:0]   ram_dq_in;

    asram_ctrl #(.AW(AW), .LANES(LANES), .CLK_NS(CLK_NS)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ram_addr(ram_addr),
        .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n),
        .ram_be_n(ram_be_n), .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe),
        .ram_dq_in(ram_dq_in)
    );

    always #2.5 clk = ~clk;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit checking = 1'b0;

    int wr_n, rd_n, hz_n, rec_n;
    initial begin
        wr_n  = cdiv(45);
        if (cdiv(50) > wr_n) wr_n = cdiv(50);
        if (cdiv(25) > wr_n) wr_n = cdiv(25);
        rd_n  = cdiv(55) + 1;
        hz_n  = cdiv(20);
        rec_n = cdiv(55) - 2 - ((wr_n < rd_n) ? wr_n : rd_n);
        if (hz_n > rec_n) rec_n = hz_n;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Pin-level RAM: storage written by the strobes, read data valid 54 ns after output enable falls.
    logic [DW-1:0] ram_mem [0:1023];
    logic [DW-1:0] gold    [0:1023];
    logic          rd_ok = 1'b0;
    initial begin
        for (int i = 0; i < 1024; i++) begin
            ram_mem[i] = '0;
            gold[i]    = '0;
        end
    end

    always @(negedge ram_oe_n) begin
        rd_ok = 1'b0;
        #54;
        rd_ok = 1'b1;
    end

    always @* begin
        for (int i = 0; i < LANES; i++) begin
            ram_dq_in[8*i +: 8] = (!ram_ce_n && !ram_oe_n && ram_we_n && rd_ok && !ram_be_n[i])
                                  ? ram_mem[ram_addr[9:0]][8*i +: 8] : 8'hE7;
        end
    end

    always @(negedge clk) begin
        if (!ram_ce_n && !ram_we_n) begin
            for (int i = 0; i < LANES; i++)
                if (!ram_be_n[i]) ram_mem[ram_addr[9:0]][8*i +: 8] = ram_dq_out[8*i +: 8];
        end
    end

    // Reference model: tracks the age of the current access in clock edges.
    bit            busy = 1'b0;
    int            age = 0;
    int            acc_n = 1;
    logic          m_we = 1'b0;
    logic [AW-1:0] m_addr = '0;
    logic [1:0]    m_be = '0;
    logic [DW-1:0] m_wd = '0;
    logic [DW-1:0] m_exp = '0;
    string         cur_tag = "R4";
    string         m_tag = "R4";

    always @(posedge clk) begin
        if (!rst_n) begin
            busy = 1'b0;
            age  = 0;
        end else if (busy) begin
            age++;
            if (age == acc_n + 3 + rec_n) busy = 1'b0;
        end else if (req_valid) begin
            busy   = 1'b1;
            age    = 1;
            m_we   = req_we;
            m_addr = req_addr;
            m_be   = req_be;
            m_wd   = req_wdata;
            m_tag  = cur_tag;
            acc_n  = req_we ? wr_n : rd_n;
            if (req_we) begin
                if (req_be[0]) gold[req_addr[9:0]][7:0]  = req_wdata[7:0];
                if (req_be[1]) gold[req_addr[9:0]][15:8] = req_wdata[15:8];
                m_exp = '0;
            end else begin
                m_exp = {req_be[1] ? gold[req_addr[9:0]][15:8] : 8'h00,
                         req_be[0] ? gold[req_addr[9:0]][7:0]  : 8'h00};
            end
        end
    end

    // Per-cycle comparison of every output against the model.
    always @(negedge clk) begin
        if (checking) begin
            bit on, drv, fin;
            on  = busy && age >= 2 && age <= acc_n + 1;
            drv = busy && m_we && age <= acc_n + 2;
            fin = busy && age == acc_n + 2;
            chk(ram_ce_n == !on, m_we ? "R1 ce" : "R3 ce", ram_ce_n, !on);
            chk(ram_we_n == !(on && m_we), "R2 we", ram_we_n, !(on && m_we));
            chk(ram_oe_n == !(on && !m_we), m_we ? "R1 oe" : "R3 oe", ram_oe_n, !(on && !m_we));
            chk(ram_be_n == ~({2{on}} & m_be), m_we ? "R1 be" : "R3 be", ram_be_n, ~({2{on}} & m_be));
            chk(ram_dq_oe == drv, "R7 drive", ram_dq_oe, drv);
            if (drv) chk(ram_dq_out == m_wd, "R2 wdata", ram_dq_out, m_wd);
            chk(ram_addr == m_addr, "R6 addr", ram_addr, m_addr);
            chk(rsp_valid == fin, "R5 rsp_valid", rsp_valid, fin);
            if (fin) chk(rsp_rdata == m_exp, m_tag, rsp_rdata, m_exp);
            chk(req_ready == !busy, "R8 ready", req_ready, !busy);
            chk(!(ram_dq_oe && !ram_oe_n), "R7 contention", ram_dq_oe, 0);
        end
    end

    task automatic do_op(input logic we, input logic [AW-1:0] a, input logic [1:0] be,
                         input logic [DW-1:0] d, input string tag);
        while (busy) @(negedge clk);
        cur_tag   = tag;
        req_valid = 1'b1;
        req_we    = we;
        req_addr  = a;
        req_be    = be;
        req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_wdata = 16'hFFFF;
        req_addr  = '1;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            bad++;
            $display("FAIL R5 watchdog act=hung exp=done");
            finish_run();
        end
    end

    logic [AW-1:0] pool [0:4];
    initial begin
        pool[0] = 17'h00010; pool[1] = 17'h1FFFF; pool[2] = 17'h00000;
        pool[3] = 17'h0A5A5; pool[4] = 17'h10200;
    end

    initial begin
        int seed;
        repeat (4) @(negedge clk);
        // R9: values held during reset
        chk(ram_ce_n && ram_we_n && ram_oe_n && (&ram_be_n), "R9 strobes", {ram_ce_n, ram_we_n, ram_oe_n, ram_be_n}, 5'h1F);
        chk(!ram_dq_oe && !rsp_valid, "R9 drive/rsp", {ram_dq_oe, rsp_valid}, 0);
        chk(req_ready, "R9 ready", req_ready, 1);
        rst_n = 1'b1;
        checking = 1'b1;
        @(negedge clk);

        do_op(1'b1, 17'h00010, 2'b11, 16'h1234, "R4");
        do_op(1'b0, 17'h00010, 2'b11, 16'h0,    "R4");
        do_op(1'b1, 17'h00010, 2'b01, 16'hABCD, "R4");
        do_op(1'b0, 17'h00010, 2'b11, 16'h0,    "R10");
        do_op(1'b1, 17'h00010, 2'b10, 16'h5566, "R4");
        do_op(1'b0, 17'h00010, 2'b11, 16'h0,    "R10");
        do_op(1'b0, 17'h00010, 2'b01, 16'h0,    "R4");
        do_op(1'b0, 17'h00010, 2'b10, 16'h0,    "R4");
        do_op(1'b0, 17'h00010, 2'b00, 16'h0,    "R4");
        do_op(1'b1, 17'h1FFFF, 2'b11, 16'hFEDC, "R4");
        do_op(1'b1, 17'h00000, 2'b11, 16'h0F0F, "R4");
        do_op(1'b0, 17'h1FFFF, 2'b11, 16'h0,    "R4");
        do_op(1'b0, 17'h00000, 2'b11, 16'h0,    "R4");
        do_op(1'b1, 17'h1FFFF, 2'b00, 16'h9999, "R4");
        do_op(1'b0, 17'h1FFFF, 2'b11, 16'h0,    "R10");

        seed = 32'h1357_9BDF;
        for (int i = 0; i < 40; i++) begin
            seed = seed * 1103515245 + 12345;
            do_op(seed[16], pool[(seed >>> 8) % 5 < 0 ? 0 : (seed >>> 8) % 5],
                  seed[5:4], seed[31:16], "R4");
        end

        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule